// File: doc/BRIEF.md
# UART Register Front End with Interrupt Gating

This block is the software-visible face of a simple serial port. A bus master presents word offsets with a select and a write flag. The block decodes the offset and updates or returns one of a small set of registers:

- one received-character holding register;
- a transmit data port;
- two control words and a baud increment word;
- two status words with per-bit write-one-to-clear behaviour;
- a read-only test/status word that reports empty conditions.

A character source delivers bytes through a valid/byte pair, and those bytes raise the receive flags. A transmit sink sees a one-cycle strobe with the byte that software wrote.

A single level interrupt combines the receive-ready and transmit-ready status bits, each gated by its enable in control word 1. A separate enable in control word 1 folds the transmit-empty flag of the test word into the interrupt. The same enable also decides whether transmit-ready may contribute at all. A rising edge on the receiver enable in control word 2 produces a one-cycle accept pulse toward the character source.

Reads return data combinationally in the cycle the select is presented. All side effects take place at the clock edge that closes that cycle.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the registers read as follows, and every other register reads 0 with `irq` low:
  - status word 1 (offset 0x25) reads 0x2000 (transmitter ready, bit 13);
  - status word 2 (offset 0x26) reads 0x4008 (transmit FIFO empty bit 14, transmit complete bit 3);
  - the test word (offset 0x2D) reads 0x0060 (transmit-empty bit 6, receive-empty bit 5).
- R2: Writes to control word 1 (0x20), control word 2 (0x21) and the baud increment word (0x29) store only bits 15:0 of the write data. A read returns that value zero-extended.
- R3: A write to offset 0x10 raises `tx_valid` for exactly the following cycle, with `tx_byte` equal to write data bits 7:0.
- R4: Writing status word 1 clears only those bits that are written as 1 and lie in mask 0x9DB0. Receiver ready (bit 9) and transmitter ready (bit 13) are unaffected.
- R5: Writing status word 2 clears only those bits that are written as 1 and lie in mask 0xBDD6. Receive data ready (bit 0), transmit complete (bit 3) and transmit FIFO empty (bit 14) cannot be cleared.
- R6: When `rx_valid` is high, the byte is stored. At the next edge, status 1 bit 9 and status 2 bit 0 are set and test bit 5 is cleared.
- R7: A read of offset 0x00 returns the stored byte in bits 7:0, with bit 15 equal to receive data ready. At the end of that cycle it clears status 1 bit 9 and status 2 bit 0 and sets test bit 5, unless a byte arrives in the same cycle, in which case the arrival wins.
- R8: A byte that arrives while receive data ready is set, and is not being read in that cycle, overwrites the stored byte and sets overrun (status 2 bit 1).
- R9: `irq` is high exactly when the flag set is nonzero. The flag set is status 1 AND control 1, restricted to bits 13 and 9. When control 1 bit 6 is set, test bit 6 is ORed into the flag set. When control 1 bit 6 is clear, bit 13 is dropped from the flag set.
- R10: A write to control word 2 that changes bit 1 from 0 to 1 raises `rx_accept` for exactly the following cycle. A write that leaves bit 1 at 1 does not.
- R11: The following are ignored and return 0 on read:
  - reads from offsets other than 0x00, 0x20, 0x21, 0x25, 0x26, 0x29 and 0x2D;
  - writes to any offset other than 0x10, 0x20, 0x21, 0x25, 0x26 and 0x29, including 0x00 and the read-only test word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Word offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the request cycle |
| rx_valid | input | 1 | A received character is present |
| rx_byte | input | CHAR_W (8) | Received character |
| rx_accept | output | 1 | One-cycle pulse: receiver just enabled |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | CHAR_W (8) | Character written for transmission |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check, on every cycle, the following timing relations:
- an arrival sets the receive flags;
- a data read without an arrival clears them;
- an arrival on top of unread data raises overrun;
- a status-2 write leaves the fixed bits set;
- the accept pulse follows only a real 0-to-1 change of the receiver enable;
- the transmit strobe follows each transmit write;
- the interrupt never rises without one of its enables.

Only the bench's scenarios show the exact values:
- the reset values and the write masks;
- the read word format with its valid bit;
- the arrival-over-read priority;
- each interrupt enable combination;
- silence on unmapped offsets.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int REG_W = 16;

    // word offsets
    localparam int OFF_RXD  = 'h00;
    localparam int OFF_TXD  = 'h10;
    localparam int OFF_CTL1 = 'h20;
    localparam int OFF_CTL2 = 'h21;
    localparam int OFF_ST1  = 'h25;
    localparam int OFF_ST2  = 'h26;
    localparam int OFF_BAUD = 'h29;
    localparam int OFF_TEST = 'h2D;

    // bit positions
    localparam int S1_TRDY   = 13;
    localparam int S1_RRDY   = 9;
    localparam int S2_TXFE   = 14;
    localparam int S2_TXDC   = 3;
    localparam int S2_ORE    = 1;
    localparam int S2_RDR    = 0;
    localparam int T_TXEMPTY = 6;
    localparam int T_RXEMPTY = 5;
    localparam int C1_TXMTEN = 6;
    localparam int C2_RXEN   = 1;
    localparam int RXD_VALID = 15;

    // clearable masks and reset values
    localparam logic [REG_W-1:0] S1_W1C  = 16'h9DB0;
    localparam logic [REG_W-1:0] S2_W1C  = 16'hBDD6;
    localparam logic [REG_W-1:0] S1_INIT = 16'h2000;
    localparam logic [REG_W-1:0] S2_INIT = 16'h4008;
    localparam logic [REG_W-1:0] T_INIT  = 16'h0060;
    localparam logic [REG_W-1:0] IRQ_SRC = 16'h2200;

    typedef struct packed {
        logic rd_rxd;
        logic wr_txd;
        logic wr_ctl1;
        logic wr_ctl2;
        logic wr_st1;
        logic wr_st2;
        logic wr_baud;
    } dec_t;

    function automatic logic [REG_W-1:0] w1c(input logic [REG_W-1:0] cur,
                                             input logic [REG_W-1:0] wval,
                                             input logic [REG_W-1:0] mask);
        return cur & ~(wval & mask);
    endfunction

endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic rd, wr;
    assign rd = sel && !we;
    assign wr = sel && we;

    always_comb begin
        dec         = '0;
        dec.rd_rxd  = rd && (addr == ADDR_W'(OFF_RXD));
        dec.wr_txd  = wr && (addr == ADDR_W'(OFF_TXD));
        dec.wr_ctl1 = wr && (addr == ADDR_W'(OFF_CTL1));
        dec.wr_ctl2 = wr && (addr == ADDR_W'(OFF_CTL2));
        dec.wr_st1  = wr && (addr == ADDR_W'(OFF_ST1));
        dec.wr_st2  = wr && (addr == ADDR_W'(OFF_ST2));
        dec.wr_baud = wr && (addr == ADDR_W'(OFF_BAUD));
    end
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  dec_t             dec,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctl1,
    output logic [REG_W-1:0] ctl2,
    output logic [REG_W-1:0] baud,
    output logic             rx_accept
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1      <= '0;
            ctl2      <= '0;
            baud      <= '0;
            rx_accept <= 1'b0;
        end else begin
            if (dec.wr_ctl1) ctl1 <= wdata;
            if (dec.wr_ctl2) ctl2 <= wdata;
            if (dec.wr_baud) baud <= wdata;
            rx_accept <= dec.wr_ctl2 && wdata[C2_RXEN] && !ctl2[C2_RXEN];
        end
    end

    // R10: pulse only after a real 0 -> 1 change of the receiver enable
    p_accept_edge_r10: assert property (@(posedge clk) disable iff (rst)
        rx_accept |-> (ctl2[C2_RXEN] && !$past(ctl2[C2_RXEN])));
endmodule

// File: rtl/uart_status_regs.sv
module uart_status_regs
    import uart_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  dec_t             dec,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_arrive,
    output logic [REG_W-1:0] st1,
    output logic [REG_W-1:0] st2,
    output logic [REG_W-1:0] test
);
    logic [REG_W-1:0] st1_n, st2_n, test_n;

    always_comb begin
        st1_n  = st1;
        st2_n  = st2;
        test_n = test;
        if (dec.wr_st1) st1_n = w1c(st1_n, wdata, S1_W1C);
        if (dec.wr_st2) st2_n = w1c(st2_n, wdata, S2_W1C);
        if (dec.rd_rxd) begin
            st1_n[S1_RRDY]    = 1'b0;
            st2_n[S2_RDR]     = 1'b0;
            test_n[T_RXEMPTY] = 1'b1;
        end
        if (rx_arrive) begin
            if (st2[S2_RDR] && !dec.rd_rxd) st2_n[S2_ORE] = 1'b1;
            st1_n[S1_RRDY]    = 1'b1;
            st2_n[S2_RDR]     = 1'b1;
            test_n[T_RXEMPTY] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st1  <= S1_INIT;
            st2  <= S2_INIT;
            test <= T_INIT;
        end else begin
            st1  <= st1_n;
            st2  <= st2_n;
            test <= test_n;
        end
    end

    // R6
    p_arrive_sets_r6: assert property (@(posedge clk) disable iff (rst)
        rx_arrive |=> (st1[S1_RRDY] && st2[S2_RDR] && !test[T_RXEMPTY]));
    // R7
    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (dec.rd_rxd && !rx_arrive) |=> (!st1[S1_RRDY] && !st2[S2_RDR] && test[T_RXEMPTY]));
    // R8
    p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_arrive && st2[S2_RDR] && !dec.rd_rxd) |=> st2[S2_ORE]);
    // R5
    p_fixed_bits_r5: assert property (@(posedge clk) disable iff (rst)
        dec.wr_st2 |=> (st2[S2_TXFE] && st2[S2_TXDC]));
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_regs_pkg::*;
(
    input  logic [REG_W-1:0] st1,
    input  logic [REG_W-1:0] ctl1,
    input  logic [REG_W-1:0] test,
    output logic             irq
);
    logic [REG_W-1:0] flags;

    always_comb begin
        flags = st1 & ctl1 & IRQ_SRC;
        if (ctl1[C1_TXMTEN]) flags[T_TXEMPTY] = test[T_TXEMPTY];
        else                 flags[S1_TRDY]   = 1'b0;
        irq = |flags;
    end
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    output logic              rx_accept,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_byte,
    output logic              irq
);
    dec_t             dec;
    logic [REG_W-1:0] wdata16;
    logic [REG_W-1:0] ctl1, ctl2, baud, st1, st2, test;
    logic [CHAR_W-1:0] rx_buf;
    logic [REG_W-1:0] rxd_word, rd_word;

    assign wdata16 = bus_wdata[REG_W-1:0];

    uart_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr), .dec(dec)
    );

    uart_ctrl_regs ctrl_i (
        .clk(clk), .rst(rst), .dec(dec), .wdata(wdata16),
        .ctl1(ctl1), .ctl2(ctl2), .baud(baud), .rx_accept(rx_accept)
    );

    uart_status_regs stat_i (
        .clk(clk), .rst(rst), .dec(dec), .wdata(wdata16), .rx_arrive(rx_valid),
        .st1(st1), .st2(st2), .test(test)
    );

    uart_irq_gen irq_i (
        .st1(st1), .ctl1(ctl1), .test(test), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_buf   <= '0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            if (rx_valid) rx_buf <= rx_byte;
            tx_valid <= dec.wr_txd;
            if (dec.wr_txd) tx_byte <= bus_wdata[CHAR_W-1:0];
        end
    end

    always_comb begin
        rxd_word            = REG_W'(rx_buf);
        rxd_word[RXD_VALID] = st2[S2_RDR];
        rd_word             = '0;
        if (bus_sel && !bus_we) begin
            case (int'(bus_addr))
                OFF_RXD:  rd_word = rxd_word;
                OFF_CTL1: rd_word = ctl1;
                OFF_CTL2: rd_word = ctl2;
                OFF_ST1:  rd_word = st1;
                OFF_ST2:  rd_word = st2;
                OFF_BAUD: rd_word = baud;
                OFF_TEST: rd_word = test;
                default:  rd_word = '0;
            endcase
        end
        bus_rdata = DATA_W'(rd_word);
    end

    // R3
    p_tx_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        dec.wr_txd |=> (tx_valid && tx_byte == $past(bus_wdata[CHAR_W-1:0])));
    // R9
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(ctl1 & (IRQ_SRC | REG_W'(1 << C1_TXMTEN)))));
endmodule

// File: tb/uart_reg_front_tb_top.sv
`timescale 1ns/1ps
module uart_reg_front_tb_top;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int CW = 8;

    localparam int SRC_RDATA = 0;
    localparam int SRC_IRQ   = 1;
    localparam int SRC_TXV   = 2;
    localparam int SRC_TXB   = 3;
    localparam int SRC_ACC   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rx_valid = 1'b0;
    logic [CW-1:0] rx_byte = '0;
    logic          rx_accept, tx_valid, irq;
    logic [CW-1:0] tx_byte;

    always #4 clk = ~clk;

    uart_reg_front #(.ADDR_W(AW), .DATA_W(DW), .CHAR_W(CW)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_accept(rx_accept),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    typedef struct {
        int          src;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // monitor: compare every queued expectation at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.src)
                    SRC_RDATA: act = bus_rdata;
                    SRC_IRQ:   act = 32'(irq);
                    SRC_TXV:   act = 32'(tx_valid);
                    SRC_TXB:   act = 32'(tx_byte);
                    default:   act = 32'(rx_accept);
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic drive(input logic s, input logic w, input int a,
                         input logic [31:0] d, input logic rv, input logic [7:0] rb);
        @(posedge clk);
        #2;
        bus_sel   = s;
        bus_we    = w;
        bus_addr  = AW'(a);
        bus_wdata = d;
        rx_valid  = rv;
        rx_byte   = rb;
    endtask

    task automatic expect_v(input int src, input logic [31:0] e, input string tag);
        item_t it;
        it.src = src;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        drive(1, 1, a, d, 0, 0);
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        drive(1, 0, a, 0, 0, 0);
        expect_v(SRC_RDATA, e, tag);
    endtask

    task automatic rx_push(input logic [7:0] b);
        drive(0, 0, 0, 0, 1, b);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        idle();
        expect_v(SRC_IRQ, 0, "R1 irq after reset");
        rd('h25, 32'h2000, "R1 status1 reset");
        rd('h26, 32'h4008, "R1 status2 reset");
        rd('h2D, 32'h0060, "R1 test reset");
        rd('h20, 32'h0, "R1 ctl1 reset");
        rd('h00, 32'h0, "R1 rxd reset");

        // R2 low 16 bits kept
        wr('h20, 32'hFFFF_0000);
        rd('h20, 32'h0, "R2 ctl1 upper bits dropped");
        wr('h29, 32'h5A5A_1234);
        rd('h29, 32'h1234, "R2 baud readback");

        // R3 transmit strobe
        wr('h10, 32'h0000_01C3);
        idle();
        expect_v(SRC_TXV, 1, "R3 tx_valid");
        expect_v(SRC_TXB, 32'hC3, "R3 tx_byte");
        idle();
        expect_v(SRC_TXV, 0, "R3 tx_valid one cycle");

        // R10 receiver enable edge
        wr('h21, 32'h0000_0002);
        idle();
        expect_v(SRC_ACC, 1, "R10 accept pulse");
        idle();
        expect_v(SRC_ACC, 0, "R10 accept one cycle");
        wr('h21, 32'h0000_0006);
        idle();
        expect_v(SRC_ACC, 0, "R10 no pulse when already enabled");
        rd('h21, 32'h0006, "R2 ctl2 readback");

        // R6 / R7 arrival and read
        rx_push(8'h5A);
        rd('h25, 32'h2200, "R6 status1 rrdy");
        rd('h26, 32'h4009, "R6 status2 rdr");
        rd('h2D, 32'h0040, "R6 rx empty cleared");
        rd('h00, 32'h805A, "R7 rxd valid word");
        rd('h25, 32'h2000, "R7 status1 after read");
        rd('h26, 32'h4008, "R7 status2 after read");
        rd('h2D, 32'h0060, "R7 rx empty set");
        rd('h00, 32'h005A, "R7 rxd not valid");

        // R9 interrupt gating
        wr('h20, 32'h0200);
        idle();
        expect_v(SRC_IRQ, 0, "R9 rx enabled, no data");
        rx_push(8'h11);
        idle();
        expect_v(SRC_IRQ, 1, "R9 rx ready irq");
        rd('h00, 32'h8011, "R7 rxd read");
        expect_v(SRC_IRQ, 1, "R9 irq during read cycle");
        idle();
        expect_v(SRC_IRQ, 0, "R9 irq drops after read");
        wr('h20, 32'h2000);
        idle();
        expect_v(SRC_IRQ, 0, "R9 trdy dropped without empty enable");
        wr('h20, 32'h2040);
        idle();
        expect_v(SRC_IRQ, 1, "R9 trdy with empty enable");
        wr('h20, 32'h0040);
        idle();
        expect_v(SRC_IRQ, 1, "R9 tx empty alone");
        wr('h20, 32'h0);
        idle();
        expect_v(SRC_IRQ, 0, "R9 all enables off");

        // R8 overrun, R5 status2 clearing
        rx_push(8'h21);
        rx_push(8'h22);
        rd('h26, 32'h400B, "R8 overrun set");
        wr('h26, 32'hFFFF);
        rd('h26, 32'h4009, "R5 only masked bits cleared");
        rd('h00, 32'h8022, "R8 newest byte kept");
        rd('h26, 32'h4008, "R5 rdr cleared by read only");

        // R4 status1 write leaves hardware bits
        rx_push(8'h55);
        wr('h25, 32'hFFFF);
        rd('h25, 32'h2200, "R4 rrdy and trdy unaffected");
        rd('h00, 32'h8055, "R4 rxd after status1 write");

        // R8 arrival during read: arrival wins, no overrun
        rx_push(8'h61);
        drive(1, 0, 'h00, 0, 1, 8'h62);
        expect_v(SRC_RDATA, 32'h8061, "R8 read old byte");
        rd('h26, 32'h4009, "R8 no overrun on read cycle");
        rd('h00, 32'h8062, "R8 new byte present");

        // R11 unmapped and read-only
        rd('h3F, 32'h0, "R11 unmapped read");
        wr('h2D, 32'h0);
        rd('h2D, 32'h0060, "R11 test word read-only");
        wr('h05, 32'hFFFF);
        rd('h05, 32'h0, "R11 unmapped write");
        wr('h00, 32'hFFFF);
        rd('h00, 32'h0062, "R11 rxd write ignored");
        idle();
        idle();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule